// File: doc/BRIEF.md
# Dual-Channel Gold Spreading Code Generator

This block produces the two spreading chip streams of a direct-sequence spread-spectrum burst link: one chip for the in-phase channel and one for the quadrature channel on every enabled chip. A transmitter uses it to spread every field of a burst. A receiver uses it as the local code replica. Three 11-bit maximal-length shift registers form a Gold code family. The in-phase code combines register A with a shared register C. The quadrature code combines register B with the same register C. A code is chosen only by the starting contents of its registers, and software supplies those contents as three seed words.

A chip-rate strobe from an external timing source advances all three registers together. A restart input reapplies the seeds at the start of each burst. The code period is fixed at 2047 chips, whatever the symbol rate, because the chips-per-symbol ratio is set elsewhere. An epoch marker therefore flags the first chip of each code period without any reference to symbol timing. The block leaves out the chip-rate oscillator, the data modulation and the acquisition logic.

Top module: `dsss_gold_pair`

## Requirements
- R1: While reset is asserted, and after it until the first restart, every register holds the value 1. As a result chip_i = 0, chip_q = 0 and epoch = 0.
- R2: On a clock edge where chip_en = 1 and restart = 0, each register moves one stage towards its output stage, bit 0. The new bit 10 is the XOR of the tapped stages, and each register's output is its bit 0.
- R3: chip_i is the XOR of the output stages of registers A and C. Register A follows the recurrence a[n+11] = a[n+2] XOR a[n], from x^11+x^2+1. Register C follows c[n+11] = c[n+8] XOR c[n+5] XOR c[n+2] XOR c[n], from x^11+x^8+x^5+x^2+1. Seed bit k is sequence element k, so the first chip after a load uses bit 0 of each seed.
- R4: chip_q is the XOR of the output stages of registers B and C. Register B uses the same recurrence as register A.
- R5: On a clock edge where restart = 1, each register loads its seed, whatever the value of chip_en. The output after that edge is chip 0 of the code.
- R6: A seed of all zeros is loaded as the value 1, so no register can enter the all-zero state.
- R7: On a clock edge where chip_en = 0 and restart = 0, the registers keep their state, so chip_i and chip_q do not change.
- R8: epoch is 1 for exactly one clock cycle after each edge that puts the registers back on their loaded values. Such an edge is either a restart or the 2047th enabled advance since the last load. On all other cycles epoch is 0, so the code repeats every 2047 enabled chips.
- R9: The seed inputs are sampled only on a restart edge. Changing them at any other time has no effect on the chip outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Advance all registers by one chip |
| restart | input | 1 | Reload all three seeds; overrides chip_en |
| seed_a | input | 11 | Initial state of register A (I code) |
| seed_b | input | 11 | Initial state of register B (Q code) |
| seed_c | input | 11 | Initial state of the shared register C |
| chip_i | output | 1 | In-phase spreading chip |
| chip_q | output | 1 | Quadrature spreading chip |
| epoch | output | 1 | First chip of a code period |

## Verification
The assertions check on every cycle the following properties. A restart loads the guarded seeds and raises the epoch marker. Each enabled advance shifts every register by one stage. An idle cycle leaves the registers unchanged. No register ever holds zero. Whenever the epoch marker is high, all three registers match the seeds captured at the last load. The actual feedback taps, the XOR combination into the two channels and the full 2047-chip wrap can only be seen in the bench scenarios. In those scenarios each output chip is compared with sequences computed from the two recurrences, under continuous and gapped enables, zero seeds, seed changes without a restart, and a run past one complete period.

// File: rtl/gold_pkg.sv
package gold_pkg;
  localparam int LFSR_W = 11;
  localparam int NUM_REGS = 3;
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_C = 2;
  // Tap masks: bit k set means stage k feeds the new top bit.
  localparam logic [LFSR_W-1:0] TAP_AB = 11'h005; // x^11 + x^2 + 1
  localparam logic [LFSR_W-1:0] TAP_C  = 11'h125; // x^11 + x^8 + x^5 + x^2 + 1

  typedef struct packed {
    logic i;
    logic q;
  } chip_pair_t;
endpackage

// File: rtl/gold_lfsr.sv
module gold_lfsr #(
  parameter int W = 11,
  parameter logic [W-1:0] TAPS = 11'h005
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state,
  output logic         out_bit
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic [W-1:0] seed_ok;
  logic         fb;

  // Lock-up guard: an all-zero seed would freeze the register.
  always_comb begin
    if (seed == '0) seed_ok = W'(1);
    else            seed_ok = seed;
  end

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = state_q;
    if (load)     state_d = seed_ok;
    else if (adv) state_d = {fb, state_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= W'(1);
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign out_bit = state_q[0];
endmodule

// File: rtl/gold_epoch.sv
module gold_epoch #(
  parameter int PERIOD = 2047
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  output logic epoch
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ep_q, ep_d;

  always_comb begin
    cnt_d = cnt_q;
    ep_d  = 1'b0;
    if (load) begin
      cnt_d = '0;
      ep_d  = 1'b1;
    end else if (adv) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        ep_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ep_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ep_q  <= ep_d;
    end
  end

  assign epoch = ep_q;
endmodule

// File: rtl/dsss_gold_pair.sv
module dsss_gold_pair
  import gold_pkg::*;
#(
  parameter int W = LFSR_W,
  parameter logic [W-1:0] TAPS_AB = TAP_AB,
  parameter logic [W-1:0] TAPS_C  = TAP_C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chip_en,
  input  logic         restart,
  input  logic [W-1:0] seed_a,
  input  logic [W-1:0] seed_b,
  input  logic [W-1:0] seed_c,
  output logic         chip_i,
  output logic         chip_q,
  output logic         epoch
);
  localparam int PERIOD = (2 ** W) - 1;

  logic [W-1:0] seeds  [NUM_REGS];
  logic [W-1:0] states [NUM_REGS];
  logic         outs   [NUM_REGS];
  logic [W-1:0] st_a, st_b, st_c;
  chip_pair_t   chips;

  assign seeds[IDX_A] = seed_a;
  assign seeds[IDX_B] = seed_b;
  assign seeds[IDX_C] = seed_c;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [W-1:0] TAP_SEL = (g == IDX_C) ? TAPS_C : TAPS_AB;
    gold_lfsr #(.W(W), .TAPS(TAP_SEL)) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (restart),
      .adv    (chip_en),
      .seed   (seeds[g]),
      .state  (states[g]),
      .out_bit(outs[g])
    );
  end

  gold_epoch #(.PERIOD(PERIOD)) u_epoch (
    .clk  (clk),
    .rst_n(rst_n),
    .load (restart),
    .adv  (chip_en),
    .epoch(epoch)
  );

  assign st_a = states[IDX_A];
  assign st_b = states[IDX_B];
  assign st_c = states[IDX_C];

  always_comb begin
    chips.i = outs[IDX_A] ^ outs[IDX_C];
    chips.q = outs[IDX_B] ^ outs[IDX_C];
  end

  assign chip_i = chips.i;
  assign chip_q = chips.q;
endmodule

// File: rtl/gold_pair_chk.sv
module gold_pair_chk #(
  parameter int W = 11
) (
  input logic         clk,
  input logic         rst_n,
  input logic         chip_en,
  input logic         restart,
  input logic [W-1:0] seed_a,
  input logic [W-1:0] seed_b,
  input logic [W-1:0] seed_c,
  input logic [W-1:0] st_a,
  input logic [W-1:0] st_b,
  input logic [W-1:0] st_c,
  input logic         epoch
);
  logic [W-1:0] cap_a, cap_b, cap_c;
  logic [W-1:0] gd_a, gd_b, gd_c;

  assign gd_a = (seed_a == '0) ? W'(1) : seed_a;
  assign gd_b = (seed_b == '0) ? W'(1) : seed_b;
  assign gd_c = (seed_c == '0) ? W'(1) : seed_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= W'(1);
      cap_b <= W'(1);
      cap_c <= W'(1);
    end else if (restart) begin
      cap_a <= gd_a;
      cap_b <= gd_b;
      cap_c <= gd_c;
    end
  end

  // R5 and R6: a restart loads the guarded seeds
  a_r5_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (st_a == $past(gd_a)) && (st_b == $past(gd_b)) && (st_c == $past(gd_c)));

  a_r5_restart_epoch: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> epoch);

  a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_a != '0) && (st_b != '0) && (st_c != '0));

  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !restart) |=> (st_a[W-2:0] == $past(st_a[W-1:1])) &&
                              (st_b[W-2:0] == $past(st_b[W-1:1])) &&
                              (st_c[W-2:0] == $past(st_c[W-1:1])));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !restart) |=> $stable(st_a) && $stable(st_b) && $stable(st_c) && !epoch);

  a_r8_epoch_single: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch && !restart) |=> !epoch);

  a_r8_epoch_at_seed: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |-> (st_a == cap_a) && (st_b == cap_b) && (st_c == cap_c));
endmodule

bind dsss_gold_pair gold_pair_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .chip_en(chip_en),
  .restart(restart),
  .seed_a (seed_a),
  .seed_b (seed_b),
  .seed_c (seed_c),
  .st_a   (st_a),
  .st_b   (st_b),
  .st_c   (st_c),
  .epoch  (epoch)
);

// File: tb/dsss_gold_pair_test.sv
module dsss_gold_pair_test;
  localparam int W = 11;
  localparam int PER = 2047;

  logic clk = 1'b0;
  logic rst_n;
  logic chip_en, restart;
  logic [W-1:0] seed_a, seed_b, seed_c;
  logic chip_i, chip_q, epoch;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  dsss_gold_pair uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .restart(restart),
    .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
    .chip_i(chip_i), .chip_q(chip_q), .epoch(epoch)
  );

  // Reference sequences built from the recurrences of R3 and R4
  bit seq [3][PER];
  int kidx = 0;
  logic [2:0] expq [$];

  task automatic build(input int r, input logic [W-1:0] sd, input logic [W-1:0] taps);
    logic [W-1:0] s;
    s = (sd == '0) ? W'(1) : sd; // R6 guard
    for (int n = 0; n < W; n++) seq[r][n] = s[n];
    for (int n = W; n < PER; n++) begin
      bit b = 0;
      for (int t = 0; t < W; t++) if (taps[t]) b ^= seq[r][n-W+t];
      seq[r][n] = b;
    end
  endtask

  task automatic step(input bit en, input bit rs);
    bit ep;
    @(negedge clk);
    chip_en = en;
    restart = rs;
    @(posedge clk);
    #1;
    ep = 0;
    if (rs) begin // R5: restart wins over chip_en
      build(0, seed_a, 11'h005);
      build(1, seed_b, 11'h005);
      build(2, seed_c, 11'h125);
      kidx = 0;
      ep = 1;
    end else if (en) begin // R2 advance, R8 wrap
      kidx = kidx + 1;
      if (kidx == PER) begin kidx = 0; ep = 1; end
    end // R7: idle keeps kidx
    expq.push_back({seq[0][kidx] ^ seq[2][kidx], seq[1][kidx] ^ seq[2][kidx], ep});
  endtask

  // Monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [2:0] e;
      e = expq.pop_front();
      n_vec++;
      if (chip_i !== e[2]) begin
        n_bad++;
        $display("FAIL R3 chip_i chip %0d: got %b expected %b", kidx, chip_i, e[2]);
      end
      if (chip_q !== e[1]) begin
        n_bad++;
        $display("FAIL R4 chip_q chip %0d: got %b expected %b", kidx, chip_q, e[1]);
      end
      if (epoch !== e[0]) begin
        n_bad++;
        $display("FAIL R8 epoch chip %0d: got %b expected %b", kidx, epoch, e[0]);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    chip_en = 1'b0;
    restart = 1'b0;
    seed_a = 11'h3A5;
    seed_b = 11'h1C7;
    seed_c = 11'h6B2;
    // R1: before any restart the model uses seeds of 1
    build(0, 11'd1, 11'h005);
    build(1, 11'd1, 11'h005);
    build(2, 11'd1, 11'h125);
    repeat (3) @(negedge clk);
    n_vec++;
    if ({chip_i, chip_q, epoch} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1 reset outputs: got %b expected 000", {chip_i, chip_q, epoch});
    end
    rst_n = 1'b1;
    // R1 and R2: advance from the reset state
    for (int n = 0; n < 30; n++) step(1, 0);
    // R5: load seeds, then run continuously
    step(0, 1);
    for (int n = 0; n < 200; n++) step(1, 0);
    // R7: gapped enable
    for (int n = 0; n < 150; n++) step(bit'($urandom_range(0, 1)), 0);
    // R9: seed changes without restart have no effect
    seed_a = 11'h012; seed_b = 11'h7FF; seed_c = 11'h400;
    for (int n = 0; n < 40; n++) step(1, 0);
    // R5: restart with chip_en high
    step(1, 1);
    for (int n = 0; n < 60; n++) step(1, 0);
    // R6: zero seeds on A and C
    seed_a = '0; seed_c = '0; seed_b = 11'h155;
    step(0, 1);
    for (int n = 0; n < 80; n++) step(1, 0);
    // R8: past one full period, with idle gaps near the wrap
    seed_a = 11'h2D3; seed_b = 11'h0A9; seed_c = 11'h5E1;
    step(0, 1);
    for (int n = 0; n < PER - 3; n++) step(1, 0);
    step(0, 0);
    for (int n = 0; n < 25; n++) step(1, 0);
    // R5: restart in mid-run
    for (int n = 0; n < 10; n++) step(1, 0);
    step(1, 1);
    for (int n = 0; n < 20; n++) step(1, 0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule